// File: doc/BRIEF.md
# Programmable Interrupt Timer Counter

This block is a down-counting timer that advances on a base tick enable. A programmable power-of-two prescaler slows the base tick by 1 to 128. Software programs the block through a single write port that reaches three registers. The first is a 32-bit start value. The second is a divider code. The third is a vector entry that holds an 8-bit vector, a mask bit and a mode bit. The live count is always visible on `count_o`.

When the count expires, the block raises `irq_o` for one cycle and presents the entry's vector on `irq_vec_o`. The event is edge-type and has no acknowledge. In periodic mode the counter reloads and keeps running. In one-shot mode it stops at zero. Accepting the interrupt and decoding the bus are left to the surrounding logic.

Top module: `tick_timer`

## Requirements
- R1: While `rst_ni` is low and after it is released, `count_o` is 0 and `irq_o` is 0. The vector entry resets to masked and one-shot with vector 0. The divider code resets to 0, which divides by 2.
- R2: A write with `wr_sel_i`=1 sets the divider code to {data[3], data[1:0]}. All other data bits are ignored. The prescaler shift is (code+1) mod 8, so code 7 divides by 1, code 0 divides by 2 and code 6 divides by 128.
- R3: Once a start value has been loaded, the count goes down by one on every 2^shift-th cycle in which `tick_i` is high. Cycles with `tick_i` low are not counted.
- R4: A write with `wr_sel_i`=0 loads data into both the start value and the count. It also restarts the prescaler, so the next decrement comes a full 2^shift ticks later. A load in the same cycle as a tick takes precedence over that tick.
- R5: Periodic mode is entry bit 17 = 1. When a prescaled tick arrives with the count at 0, the count reloads the start value and an expiry occurs. The period is (start value + 1) prescaled ticks.
- R6: One-shot mode is entry bit 17 = 0. For a nonzero start value V, exactly one expiry occurs, on prescaled tick V+1 after the load. The count then stays 0 until the next load.
- R7: In one-shot mode, a start value of 0 never produces an expiry.
- R8: While the mask bit (entry bit 16) is 1, an expiry does not raise `irq_o`. Counting continues as normal.
- R9: An unmasked expiry drives `irq_o` high for the cycle after the tick, with `irq_vec_o` equal to entry bits 7:0. A write with `wr_sel_i`=2 sets the entry. The new value governs every later tick.
- R10: A write with `wr_sel_i`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Base tick enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 start value, 1 divider, 2 vector entry, 3 none |
| wr_data_i | input | 32 | Write data |
| count_o | output | 32 | Current count |
| irq_o | output | 1 | One-cycle interrupt request |
| irq_vec_o | output | 8 | Vector carried with the request |

## Verification
The assertions check several rules on every cycle:
- the count changes only by a load, a decrement of one, or a reload of the start value;
- a load appears on the count in the next cycle;
- a periodic expiry always shows the start value on the count;
- a stopped one-shot count stays at zero;
- no request follows a cycle in which the mask was set.

Some behaviour depends on counting ticks, which only the bench's scenarios can show. This covers the divider code decoding with junk in the ignored bits, the exact tick on which each expiry falls for every code and mode, the restart of the prescaler on a reload, a mask change in the middle of a run, and the ignored select value.

// File: rtl/tick_timer_pkg.sv
`timescale 1ns/1ps
package tick_timer_pkg;
  typedef enum logic [1:0] {
    SEL_COUNT = 2'd0,
    SEL_DIV   = 2'd1,
    SEL_ENTRY = 2'd2,
    SEL_NONE  = 2'd3
  } sel_e;

  localparam int unsigned VEC_W    = 8;
  localparam int unsigned MASK_BIT = 16;
  localparam int unsigned PER_BIT  = 17;
  localparam int unsigned SHIFT_W  = 3;

  typedef struct packed {
    logic             periodic;
    logic             mask;
    logic [VEC_W-1:0] vec;
  } entry_t;

  // code 7 wraps to shift 0 (divide by 1)
  function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [SHIFT_W-1:0] code);
    return code + SHIFT_W'(1);
  endfunction
endpackage

// File: rtl/tick_timer_prescaler.sv
`timescale 1ns/1ps
module tick_timer_prescaler #(
  parameter int unsigned SHIFT_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic               tick_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               step_o
);
  localparam int unsigned PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   span_w;
  logic [PRE_W:0]   lim_w;
  logic             at_lim_w;

  assign span_w   = {{PRE_W{1'b0}}, 1'b1} << shift_i;
  assign lim_w    = span_w - 1'b1;
  // >= keeps a divider shrink mid-run from overrunning
  assign at_lim_w = {1'b0, pre_q} >= lim_w;
  assign step_o   = tick_i && !restart_i && at_lim_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else if (tick_i)    pre_q <= at_lim_w ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/tick_timer_counter.sv
`timescale 1ns/1ps
module tick_timer_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  input  logic             periodic_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] init_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] init_q, cur_q;
  logic             loaded_q, done_q;
  logic             at_zero_w;

  assign at_zero_w = cur_q == '0;
  assign expire_o  = step_i && !load_i && loaded_q && at_zero_w &&
                     (periodic_i || (!done_q && init_q != '0));
  assign count_o   = cur_q;
  assign init_o    = init_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q   <= '0;
      cur_q    <= '0;
      loaded_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (load_i) begin
      init_q   <= load_val_i;
      cur_q    <= load_val_i;
      loaded_q <= 1'b1;
      done_q   <= 1'b0;
    end else if (step_i && loaded_q) begin
      if (!at_zero_w)      cur_q  <= cur_q - 1'b1;
      else if (periodic_i) cur_q  <= init_q;
      else                 done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic [VEC_W-1:0] irq_vec_o
);
  entry_t             entry_q;
  logic [SHIFT_W-1:0] div_code_q;
  logic               irq_q;
  logic [VEC_W-1:0]   vec_q;

  logic               load_w, step_w, expire_w;
  logic               mask_w, periodic_w;
  logic [CNT_W-1:0]   init_val;
  logic [SHIFT_W-1:0] shift_w;

  assign load_w     = wr_en_i && (wr_sel_i == SEL_COUNT);
  assign mask_w     = entry_q.mask;
  assign periodic_w = entry_q.periodic;
  assign shift_w    = code_to_shift(div_code_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_q    <= '{periodic: 1'b0, mask: 1'b1, vec: '0};
      div_code_q <= '0;
    end else if (wr_en_i) begin
      unique case (wr_sel_i)
        SEL_DIV:   div_code_q <= {wr_data_i[3], wr_data_i[1:0]};
        SEL_ENTRY: entry_q    <= '{periodic: wr_data_i[PER_BIT],
                                   mask:     wr_data_i[MASK_BIT],
                                   vec:      wr_data_i[VEC_W-1:0]};
        default: ;
      endcase
    end
  end

  tick_timer_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (load_w),
    .tick_i    (tick_i),
    .shift_i   (shift_w),
    .step_o    (step_w)
  );

  tick_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_w),
    .load_val_i (wr_data_i),
    .step_i     (step_w),
    .periodic_i (periodic_w),
    .count_o    (count_o),
    .init_o     (init_val),
    .expire_o   (expire_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= expire_w && !mask_w;
      if (expire_w && !mask_w) vec_q <= entry_q.vec;
    end
  end

  assign irq_o     = irq_q;
  assign irq_vec_o = vec_q;
endmodule

// File: rtl/tick_timer_chk.sv
`timescale 1ns/1ps
module tick_timer_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       wr_sel_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic [CNT_W-1:0] count_o,
  input logic             irq_o,
  input logic             mask_w,
  input logic             periodic_w,
  input logic [CNT_W-1:0] init_val
);
  logic load_c;
  assign load_c = wr_en_i && (wr_sel_i == 2'd0);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_state: assert (count_o == '0 && !irq_o);
    end
  end

  a_r4_load_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_c) |-> count_o == $past(wr_data_i));

  a_r3_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(load_c) && count_o != $past(count_o)) |->
      (count_o == $past(count_o) - CNT_W'(1) || count_o == $past(init_val)));

  a_r5_periodic_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && $past(periodic_w)) |-> count_o == $past(init_val));

  a_r6_oneshot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(count_o) == '0 && !$past(periodic_w) && !$past(load_c)) |-> count_o == '0);

  a_r8_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !$past(mask_w));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .wr_data_i  (wr_data_i),
  .count_o    (count_o),
  .irq_o      (irq_o),
  .mask_w     (mask_w),
  .periodic_w (periodic_w),
  .init_val   (init_val)
);

// File: tb/tb_tick_timer.sv
`timescale 1ns/1ps
module tb_tick_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = 2'd0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] count_o;
  logic        irq_o;
  logic [7:0]  irq_vec_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [31:0] m_v = '0;
  bit          m_per = 1'b0;
  bit          m_mask = 1'b1;
  logic [7:0]  m_vec = '0;
  int          m_shift = 1;
  longint      m_nb = 0;

  tick_timer dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .count_o(count_o),
    .irq_o(irq_o), .irq_vec_o(irq_vec_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic longint exp_count();
    longint n = m_nb >>> m_shift;
    longint v = longint'(m_v);
    if (m_per) return v - (n % (v + 1));
    return (n >= v) ? 0 : v - n;
  endfunction

  function automatic bit exp_fire();
    longint div = longint'(1) <<< m_shift;
    longint n = m_nb >>> m_shift;
    longint v = longint'(m_v);
    if (m_nb == 0 || (m_nb % div) != 0 || m_mask) return 1'b0;
    if (m_per) return (n % (v + 1)) == 0;
    return (v != 0) && (n == v + 1);
  endfunction

  task automatic wr(logic [1:0] s, logic [31:0] d);
    wr_en_i = 1'b1; wr_sel_i = s; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    case (s)
      2'd0: begin m_v = d; m_nb = 0; end
      2'd1: m_shift = (int'({d[3], d[1:0]}) + 1) % 8;
      2'd2: begin m_per = d[17]; m_mask = d[16]; m_vec = d[7:0]; end
      default: ;
    endcase
  endtask

  task automatic tk(bit t, string req);
    bit f;
    tick_i = t;
    @(negedge clk_i);
    tick_i = 1'b0;
    if (t) m_nb++;
    f = t && exp_fire();
    check(req, count_o, 32'(exp_count()));
    check(req, {31'b0, irq_o}, {31'b0, f});
    if (f) check("R9 vector", {24'b0, irq_vec_o}, {24'b0, m_vec});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1 reset count", count_o, 32'd0);
    check("R1 reset irq", {31'b0, irq_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int i = 0; i < 10; i++) tk(1'b1, "R1 idle after reset");
    // default entry masked, default divide by 2
    wr(2'd0, 32'd1);
    for (int i = 0; i < 8; i++) tk(1'b1, "R1 masked default");

    // sweep divider codes, modes and start values; junk in ignored divider bits
    for (int c = 0; c < 8; c++) begin
      for (int p = 0; p < 2; p++) begin
        for (int k = 0; k < 3; k++) begin
          logic [31:0] v;
          logic [31:0] d;
          int t;
          v = (k == 0) ? 32'd0 : (k == 1) ? 32'd1 : 32'd5;
          d = (32'(c) & 32'h3) | ((32'(c) & 32'h4) << 1) |
              ((c % 2 == 0) ? 32'h5A5A_5A54 : 32'hA5A5_A5A4);
          wr(2'd1, d);
          wr(2'd2, (32'(p) << 17) | 32'(8'(c * 16 + k * 4 + p)));
          wr(2'd0, v);
          t = (2 * int'(v) + 3) << m_shift;
          for (int i = 0; i < t; i++)
            tk(1'b1, p ? "R2 R3 R5 periodic" : (k == 0 ? "R7 zero one-shot" : "R2 R3 R6 one-shot"));
        end
      end
    end

    // mask set, cleared and set again mid-run
    wr(2'd1, 32'h0000_000B);
    wr(2'd2, (32'd1 << 17) | (32'd1 << 16) | 32'h3C);
    wr(2'd0, 32'd2);
    for (int i = 0; i < 9; i++) tk(1'b1, "R8 masked");
    wr(2'd2, (32'd1 << 17) | 32'h3C);
    for (int i = 0; i < 9; i++) tk(1'b1, "R8 unmasked");
    wr(2'd2, (32'd1 << 17) | (32'd1 << 16) | 32'h3C);
    for (int i = 0; i < 6; i++) tk(1'b1, "R8 masked again");

    // reload mid-run restarts the prescaler; gaps in tick
    wr(2'd1, 32'h0000_0001);
    wr(2'd2, (32'd1 << 17) | 32'h77);
    wr(2'd0, 32'd10);
    for (int i = 0; i < 6; i++) tk(1'b1, "R4 first run");
    wr(2'd0, 32'd7);
    check("R4 load value", count_o, 32'd7);
    for (int i = 0; i < 60; i++) tk(i % 3 != 2, "R3 R4 gapped ticks");

    // vector change applies to later expiries
    wr(2'd2, (32'd1 << 17) | 32'hA5);
    for (int i = 0; i < 40; i++) tk(1'b1, "R9 new vector");

    // select 3 is ignored
    wr(2'd3, 32'hFFFF_FFFF);
    for (int i = 0; i < 40; i++) tk(1'b1, "R10 ignored write");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule